// File: doc/BRIEF.md
# Timed Pin-Mask Sequence Player

This block drives a 32-bit output pin bank from a list of timing records that a host has placed in a shared memory buffer. Each record is 8 bytes and holds a pin word and a delay. The player puts the pin word on the output bank, then holds it for the stated number of clock cycles before it applies the next record. The host prepares a segment of records, then starts playback by giving a byte base address and a record count. When the final record's delay runs out, the block sends a one-cycle completion pulse. The host can then reclaim and refill the buffer.

Records are read over a synchronous 64-bit memory read port. Read data arrives one cycle after the request. A small prefetch queue fetches the following records while the current delay is counting down. As a result, the spacing between two records is always the delay plus one cycle, even when every delay is zero.

Top module: `pinseq_player`

## Requirements
- R1: While reset is high and in the first cycle after it, `pins` is 0 and `busy`, `done`, `err` and `mem_rd_en` are all 0.
- R2: Record i of a segment is read from byte address base + 8*i. In the 64-bit read word, bits 31:0 hold the pin word (lower address) and bits 63:32 hold the delay (address +4).
- R3: When `start` is sampled high with `busy` low, `busy` rises at that edge. The pin word of the first record drives `pins` from the third edge after it onward.
- R4: Each following record's pin word appears exactly delay+1 cycles after the previous record's pin word, where delay is the previous record's delay. A delay of 0 gives updates on consecutive cycles.
- R5: `pins` changes only when a record is applied. It holds the last pin word after the segment ends.
- R6: `done` is a single-cycle pulse that rises delay+1 cycles after the last record is applied. `busy` falls at the same edge.
- R7: A start with a record count of 0 issues no reads and leaves `pins` unchanged. It pulses `done` one edge after the start edge.
- R8: A `start` sampled while `busy` is high is ignored and the running segment continues unchanged. It sets `err`, which stays set until the next accepted start clears it.
- R9: Reads are issued only while `busy` is high, in ascending record order, exactly as many as the record count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a segment (accepted only while idle) |
| start_base | input | ADDR_W | Byte address of the first record |
| start_count | input | CNT_W | Number of records in the segment |
| mem_rd_en | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Byte address of the requested record |
| mem_rd_data | input | 64 | Record read data, valid one cycle after the request |
| pins | output | 32 | Output pin bank |
| busy | output | 1 | Segment in progress |
| done | output | 1 | One-cycle segment completion pulse |
| err | output | 1 | Sticky flag: a start arrived while busy |

## Verification
The bench predicts the exact cycle of every pin update from the accumulated delays and compares `pins`, `busy`, `done` and `err` in every cycle of each segment.

It targets these corner cases:
- **Runs of zero delays.** A prefetch that falls behind would stall or repeat a pin word.
- **A long delay in the middle of a segment.** A counter that is off by one would shift every later update.
- **A zero-length segment.** A wrong design would read memory or change the pins.
- **A start that arrives while busy.** A careless design would reload its address or count, or miss setting the error flag.

Read addresses are also compared against the record order. A wrong record stride or word order would show up as wrong addresses or wrong pin words.

// File: rtl/pinseq_pkg.sv
package pinseq_pkg;

    localparam int PIN_W     = 32;
    localparam int DLY_W     = 32;
    localparam int REC_W     = PIN_W + DLY_W;
    localparam int REC_BYTES = REC_W / 8;

    // Packed so that the delay sits in the upper half (address +4)
    typedef struct packed {
        logic [DLY_W-1:0] delay;
        logic [PIN_W-1:0] pins;
    } rec_t;

    function automatic rec_t unpack_rec(input logic [REC_W-1:0] word);
        return rec_t'(word);
    endfunction

endpackage

// File: rtl/pinseq_fetch.sv
module pinseq_fetch
    import pinseq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int QDEPTH = 2,
    localparam int QCW   = $clog2(QDEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic [CNT_W-1:0]  num,
    input  logic [QCW-1:0]    q_count,
    input  logic              pop,
    output logic              rd_en,
    output logic [ADDR_W-1:0] addr,
    output logic              rvalid
);
    localparam int OW = QCW + 1;

    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  left_q;
    logic [OW-1:0]     occ;

    // queue entries plus the read in flight, less the entry leaving now
    assign occ   = {1'b0, q_count} + OW'(rvalid) - OW'(pop);
    assign rd_en = (left_q != '0) && (occ < OW'(QDEPTH));
    assign addr  = addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            left_q <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd_en;
            if (load) begin
                addr_q <= base;
                left_q <= num;
            end else if (rd_en) begin
                addr_q <= addr_q + ADDR_W'(REC_BYTES);
                left_q <= left_q - 1'b1;
            end
        end
    end

    // R2: consecutive requests step by one record
    assert_stride_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !load) |=> (addr == $past(addr) + ADDR_W'(REC_BYTES)));

endmodule

// File: rtl/pinseq_queue.sv
module pinseq_queue
    import pinseq_pkg::*;
#(
    parameter int QDEPTH = 2,
    localparam int QCW   = $clog2(QDEPTH + 1),
    localparam int PW    = (QDEPTH > 1) ? $clog2(QDEPTH) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  rec_t           wr_data,
    input  logic           rd_en,
    output rec_t           rd_data,
    output logic [QCW-1:0] count
);
    rec_t          slots [QDEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(QDEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign rd_data = slots[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_en) begin
                slots[wr_ptr] <= wr_data;
                wr_ptr        <= bump(wr_ptr);
            end
            if (rd_en) rd_ptr <= bump(rd_ptr);
            if (wr_en && !rd_en)      count <= count + 1'b1;
            else if (!wr_en && rd_en) count <= count - 1'b1;
        end
    end

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (count < QCW'(QDEPTH)));

    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (count != '0));

endmodule

// File: rtl/pinseq_timer.sv
module pinseq_timer
    import pinseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             want,
    input  logic             avail,
    input  rec_t             head,
    output logic             pop,
    output logic             expired,
    output logic [PIN_W-1:0] pins
);
    logic [DLY_W-1:0] cnt;

    assign expired = (cnt == '0);
    assign pop     = want && avail && expired;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            pins <= '0;
        end else if (pop) begin
            pins <= head.pins;
            cnt  <= head.delay;
        end else if (!expired) begin
            cnt <= cnt - 1'b1;
        end
    end

    assert_apply_R4: assert property (@(posedge clk) disable iff (rst)
        pop |=> (pins == $past(head.pins)));

    assert_pins_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !pop |=> $stable(pins));

    assert_wait_R4: assert property (@(posedge clk) disable iff (rst)
        (!expired && !pop) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/pinseq_player.sv
module pinseq_player
    import pinseq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int QDEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_base,
    input  logic [CNT_W-1:0]  start_count,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [REC_W-1:0]  mem_rd_data,
    output logic [PIN_W-1:0]  pins,
    output logic              busy,
    output logic              done,
    output logic              err
);
    localparam int QCW = $clog2(QDEPTH + 1);

    logic             start_ok, fin, want, pop, expired, q_wr;
    logic [QCW-1:0]   q_cnt;
    rec_t             q_head;
    logic [CNT_W-1:0] play_left;

    assign start_ok = start && !busy;
    assign want     = busy && (play_left != '0);
    assign fin      = busy && (play_left == '0) && expired;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            done      <= 1'b0;
            err       <= 1'b0;
            play_left <= '0;
        end else begin
            done <= fin;
            if (start_ok) begin
                busy      <= 1'b1;
                play_left <= start_count;
                err       <= 1'b0;
            end else begin
                if (start) err       <= 1'b1;
                if (fin)   busy      <= 1'b0;
                if (pop)   play_left <= play_left - 1'b1;
            end
        end
    end

    pinseq_fetch #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .QDEPTH(QDEPTH)) u_fetch (
        .clk    (clk),
        .rst    (rst),
        .load   (start_ok),
        .base   (start_base),
        .num    (start_count),
        .q_count(q_cnt),
        .pop    (pop),
        .rd_en  (mem_rd_en),
        .addr   (mem_addr),
        .rvalid (q_wr)
    );

    pinseq_queue #(.QDEPTH(QDEPTH)) u_queue (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (q_wr),
        .wr_data(unpack_rec(mem_rd_data)),
        .rd_en  (pop),
        .rd_data(q_head),
        .count  (q_cnt)
    );

    pinseq_timer u_timer (
        .clk    (clk),
        .rst    (rst),
        .want   (want),
        .avail  (q_cnt != '0),
        .head   (q_head),
        .pop    (pop),
        .expired(expired),
        .pins   (pins)
    );

    assert_start_R3: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && !err));

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_end_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    assert_err_cause_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> $past(start && busy));

    assert_read_busy_R9: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> busy);

endmodule

// File: tb/sim_pinseq_player.sv
`timescale 1ns/1ps
module sim_pinseq_player;

    localparam int NREC = 64;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [15:0] start_base;
    logic [15:0] start_count;
    logic        mem_rd_en;
    logic [15:0] mem_addr;
    logic [63:0] mem_rd_data;
    logic [31:0] pins;
    logic        busy, done, err;

    logic [63:0] mem [NREC];
    int          n_chk = 0;
    int          n_bad = 0;
    logic [31:0] prev_pins = '0;

    always #2.5 clk = ~clk;

    pinseq_player u0 (
        .clk(clk), .rst(rst), .start(start), .start_base(start_base),
        .start_count(start_count), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
        .mem_rd_data(mem_rd_data), .pins(pins), .busy(busy), .done(done), .err(err)
    );

    // synchronous memory model, one cycle of read latency
    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= mem[mem_addr[8:3]];
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int rec_delay(input int idx);
        return int'(mem[idx][63:32]);
    endfunction

    function automatic logic [31:0] rec_pins(input int idx);
        return mem[idx][31:0];
    endfunction

    // Play one segment and compare every cycle against the predicted timeline
    task automatic run_seg(input int rb, input int n, input bit do_inj);
        int app [NREC];
        int t, done_k, inj, nrd;
        logic [31:0] exp_p;
        string ptag;
        t = 3;
        for (int j = 0; j < n; j++) begin
            app[j] = t;
            t += rec_delay(rb + j) + 1;
        end
        done_k = (n == 0) ? 1 : t;
        inj = (do_inj && done_k > 2) ? 1 + int'($urandom % (done_k - 1)) : 0;
        nrd = 0;
        @(negedge clk);
        start       = 1'b1;
        start_base  = 16'(rb * 8);
        start_count = 16'(n);
        @(posedge clk);
        for (int k = 0; k <= done_k + 2; k++) begin
            @(negedge clk);
            if (k == 0) start = 1'b0;
            exp_p = prev_pins;
            for (int j = 0; j < n; j++) if (app[j] <= k) exp_p = rec_pins(rb + j);
            if (n == 0)                    ptag = "R7 pins";
            else if (k <= app[0])          ptag = "R3 pins";
            else if (k <= app[n-1])        ptag = "R4 pins";
            else                           ptag = "R5 pins";
            chk(ptag, 64'(pins), 64'(exp_p));
            chk("R6 busy", 64'(busy), 64'(k < done_k));
            chk((n == 0) ? "R7 done" : "R6 done", 64'(done), 64'(k == done_k));
            chk("R8 err", 64'(err), 64'(inj > 0 && k >= inj + 1));
            if (mem_rd_en) begin
                chk("R9 read beyond count", 64'(nrd < n), 64'(1));
                chk("R2 read address", 64'(mem_addr), 64'((rb + nrd) * 8));
                nrd++;
            end
            if (inj > 0 && k == inj) begin
                start       = 1'b1;
                start_base  = 16'($urandom % 512);
                start_count = 16'(1 + $urandom % 7);
            end
            if (inj > 0 && k == inj + 1) start = 1'b0;
        end
        chk((n == 0) ? "R7 read count" : "R9 read count", 64'(nrd), 64'(n));
        if (n > 0) prev_pins = rec_pins(rb + n - 1);
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd24681));
        for (int i = 0; i < NREC; i++)
            mem[i] = {32'($urandom % 5), $urandom};
        for (int i = 0; i < 8; i++) mem[i][63:32] = '0;   // back-to-back run
        mem[10][63:32] = 32'd37;                          // long delay mid-segment
        rst = 1'b1; start = 1'b0; start_base = '0; start_count = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 pins", 64'(pins), 64'(0));
        chk("R1 busy/done/err/rd", 64'({busy, done, err, mem_rd_en}), 64'(0));
        rst = 1'b0;
        @(negedge clk);
        chk("R1 idle after reset", 64'({busy, done, err, mem_rd_en}), 64'(0));

        run_seg(0, 0, 1'b0);    // empty segment
        run_seg(0, 8, 1'b0);    // zero delays
        run_seg(8, 1, 1'b0);    // single record
        run_seg(9, 4, 1'b1);    // long delay plus start while busy
        run_seg(20, 0, 1'b0);   // empty segment after an error
        for (int s = 0; s < 12; s++)
            run_seg(int'($urandom % 50), 1 + int'($urandom % 12), 1'($urandom % 2));

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule